// File: doc/BRIEF.md
# Register Command Sequence Executor

This block takes one fixed-size command record at a time and turns it into a series of accesses on a simple 32-bit register bus. The bus has separate read and write request/acknowledge pairs. A 4-byte header in each record selects one of four register operations or a null operation, and gives the number of payload bytes. The payload is then walked as a list of elements.

The four register operations are:
- **Masked-merge list:** applies a list of address/mask/value triples.
- **Chained field update:** makes one optional read and then writes a running value through a series of mask/value pairs, with no read between the writes.
- **Repeated write:** writes a list of data words to one fixed address.
- **Poll:** reads a register until a masked field equals an expected value, or until a timeout counted in microsecond ticks runs out.

When a command ends, the block pulses `done` for one cycle. It reports error and timeout flags with that pulse and holds them until the next command is accepted.

States:
- `ST_IDLE`: accepting a command.
- `ST_DECODE`: checking the header.
- `ST_RMW_NEXT`: choosing the next triple.
- `ST_FIELD_START` is not used. A chained update goes from decode straight to `ST_READ` or `ST_APPLY`.
- `ST_BURST_NEXT`: loading the next repeated word.
- `ST_READ`: a bus read.
- `ST_APPLY`: merging mask and value into the running word.
- `ST_WRITE`: a bus write.
- `ST_POLL`: poll reads.
- `ST_FINISH`: the done pulse.

Transitions:
- IDLE to DECODE when `cmd_valid` is high.
- DECODE to FINISH for null or illegal commands. Otherwise DECODE goes to the first step of the operation.
- RMW_NEXT to READ, APPLY or FINISH.
- READ to APPLY on `rd_ack`.
- APPLY to WRITE.
- WRITE, on `wr_ack`, goes back to RMW_NEXT, APPLY, BURST_NEXT or FINISH.
- BURST_NEXT to WRITE or FINISH.
- POLL to FINISH on a match or on expiry.
- FINISH to IDLE.

Top module: `regseq_engine`

## Requirements
- R1: After reset `cmd_ready` is 1 and `rd_req`, `wr_req`, `done`, `err` and `timeout` are all 0.
- R2: Word k of a record is `cmd_record[32k+31:32k]`. Word 0 is the header: type in bits 7:0, payload byte count in bits 29:24. Type codes are 0 null, 1 masked-merge list, 2 chained field update, 3 repeated write, 4 poll. Type 0 completes with `done` and no bus traffic.
- R3: In a type-1 command, element i is address word 1+3i, mask word 2+3i and value word 3+3i, with count/12 elements. For a mask that is not all ones, the block reads the address and writes `(read & ~mask) | (value & mask)` to it.
- R4: A type-1 element whose mask is 0xFFFFFFFF is written as the plain value with no read. Up to 5 elements are processed in order.
- R5: A type-2 command has its address in word 1 and pair i as mask word 2+2i and value word 3+2i, with (count-4)/8 pairs. It reads once, then for each pair merges into the running value and writes it, with no further reads.
- R6: If the first type-2 mask is 0xFFFFFFFF, no read is made and every pair is still written in order.
- R7: A type-3 command writes data words 2..(1+(count-4)/4), up to 14 of them, to the address in word 1, in order and at the same address.
- R8: A type-4 command (address word 1, mask word 2, expected word 3, limit word 4) reads repeatedly until `(rd_data & mask) == expected`, then completes with `timeout` 0.
- R9: The poll timeout counts `us_tick` pulses from command start. A read that mismatches once the count has reached the limit ends the command with `timeout` 1 and `err` 0. At least one read is always made, so a limit of 0 gives exactly one read.
- R10: Any of the following ends the command with `err` 1 and no bus access:
  - a type code above 4;
  - a type-1 count that is not a multiple of 12 or exceeds 60;
  - a type-2 or type-3 count below 4, or one whose excess over 4 is not a multiple of 8 (type 2) or 4 (type 3);
  - a type-4 count other than 16.
- R11: `cmd_ready` is high only when idle, and `cmd_valid` is ignored while busy. `done` lasts exactly one cycle.
- R12: Commands with zero elements complete with no bus traffic and `err` 0. These are type 1 with count 0, and types 2 and 3 with count 4.
- R13: A bus request holds its address (and write data) until acknowledged, and a read and a write are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command record offered |
| cmd_ready | output | 1 | Block idle, record taken this cycle if valid |
| cmd_record | input | 512 | Sixteen 32-bit words, header in word 0 |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 32 | Read address |
| rd_ack | input | 1 | Read complete, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write complete |
| done | output | 1 | One-cycle command completion pulse |
| err | output | 1 | Last command was rejected |
| timeout | output | 1 | Last poll command ran out of time |

## Verification
The masked-merge list is driven with a mix of partial and all-ones masks. This shows whether the read is skipped only for the all-ones case and whether the merge keeps the unmasked bits. Chained updates with and without a leading all-ones mask show whether the running value carries from pair to pair without re-reading. Poll commands against a register whose value counts up on every read cover three cases: a match, an expiry with a limit above zero, and an expiry with a zero limit. Together they separate completion by match from completion by expiry, and they check the exact number of reads. A set of malformed headers, plus a command offered while busy, checks that nothing reaches the bus when it should not.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    localparam int WORD_W     = 32;
    localparam int REC_WORDS  = 16;
    localparam int REC_W      = WORD_W * REC_WORDS;
    localparam int IDX_W      = $clog2(REC_WORDS);

    // header field positions
    localparam int TYPE_LSB   = 0;
    localparam int TYPE_W     = 8;
    localparam int COUNT_LSB  = 24;
    localparam int COUNT_W    = 6;

    // command type codes
    localparam logic [TYPE_W-1:0] CMD_NULL  = 8'd0;
    localparam logic [TYPE_W-1:0] CMD_MERGE = 8'd1;
    localparam logic [TYPE_W-1:0] CMD_CHAIN = 8'd2;
    localparam logic [TYPE_W-1:0] CMD_REPT  = 8'd3;
    localparam logic [TYPE_W-1:0] CMD_POLL  = 8'd4;

    // payload geometry
    localparam int MERGE_ELEM_BYTES = 12;
    localparam int MERGE_MAX        = 5;
    localparam int ADDR_WORD_BYTES  = 4;
    localparam int CHAIN_ELEM_BYTES = 8;
    localparam int CHAIN_MAX        = 7;
    localparam int REPT_ELEM_BYTES  = 4;
    localparam int REPT_MAX         = 14;
    localparam int POLL_BYTES       = 16;

    localparam logic [WORD_W-1:0] FULL_MASK = '1;

    typedef enum logic [2:0] {
        OP_NULL,
        OP_MERGE,
        OP_CHAIN,
        OP_REPT,
        OP_POLL
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RMW_NEXT,
        ST_BURST_NEXT,
        ST_READ,
        ST_APPLY,
        ST_WRITE,
        ST_POLL,
        ST_FINISH
    } state_e;

    function automatic logic [WORD_W-1:0] mask_merge(
        input logic [WORD_W-1:0] base,
        input logic [WORD_W-1:0] mask,
        input logic [WORD_W-1:0] value
    );
        return (base & ~mask) | (value & mask);
    endfunction

endpackage

// File: rtl/regseq_decode.sv
module regseq_decode
    import regseq_pkg::*;
(
    input  logic [TYPE_W-1:0]  cmd_type,
    input  logic [COUNT_W-1:0] pay_bytes,
    output op_e                op,
    output logic [IDX_W-1:0]   n_elem,
    output logic               legal
);

    always_comb begin
        int unsigned pb;
        int unsigned q;
        pb     = 32'(pay_bytes);
        q      = 0;
        op     = OP_NULL;
        legal  = 1'b0;
        unique case (cmd_type)
            CMD_NULL: begin
                op    = OP_NULL;
                legal = 1'b1;
            end
            CMD_MERGE: begin
                op    = OP_MERGE;
                q     = pb / MERGE_ELEM_BYTES;
                legal = (pb % MERGE_ELEM_BYTES == 0) && (q <= MERGE_MAX);
            end
            CMD_CHAIN: begin
                op = OP_CHAIN;
                if (pb >= ADDR_WORD_BYTES) begin
                    q     = (pb - ADDR_WORD_BYTES) / CHAIN_ELEM_BYTES;
                    legal = ((pb - ADDR_WORD_BYTES) % CHAIN_ELEM_BYTES == 0)
                            && (q <= CHAIN_MAX);
                end
            end
            CMD_REPT: begin
                op = OP_REPT;
                if (pb >= ADDR_WORD_BYTES) begin
                    q     = (pb - ADDR_WORD_BYTES) / REPT_ELEM_BYTES;
                    legal = ((pb - ADDR_WORD_BYTES) % REPT_ELEM_BYTES == 0)
                            && (q <= REPT_MAX);
                end
            end
            CMD_POLL: begin
                op    = OP_POLL;
                legal = (pb == POLL_BYTES);
            end
            default: begin
                op    = OP_NULL;
                legal = 1'b0;
            end
        endcase
        n_elem = IDX_W'(q);
    end

endmodule

// File: rtl/regseq_timer.sv
module regseq_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] elapsed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (clr) begin
            elapsed <= '0;
        end else if (tick && (elapsed != '1)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign expired = (elapsed >= limit);

endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
    import regseq_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [REC_W-1:0]  cmd_record,
    input  logic              us_tick,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              done,
    output logic              err,
    output logic              timeout
);

    state_e            state_q, state_d;
    logic [REC_W-1:0]  rec_q;
    op_e               op_q;
    logic [IDX_W-1:0]  count_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] acc_q;
    logic              err_q;
    logic              tmo_q;

    op_e               dec_op;
    logic [IDX_W-1:0]  dec_count;
    logic              dec_legal;
    logic              tmr_expired;

    function automatic logic [WORD_W-1:0] word_at(
        input logic [REC_W-1:0] r,
        input logic [IDX_W-1:0] k
    );
        return r[{k, 5'b0} +: WORD_W];
    endfunction

    // ------------------------------------------------------------------
    // header check
    // ------------------------------------------------------------------
    regseq_decode u_decode (
        .cmd_type  (rec_q[TYPE_LSB +: TYPE_W]),
        .pay_bytes (rec_q[COUNT_LSB +: COUNT_W]),
        .op        (dec_op),
        .n_elem    (dec_count),
        .legal     (dec_legal)
    );

    // ------------------------------------------------------------------
    // poll timeout
    // ------------------------------------------------------------------
    logic [WORD_W-1:0] poll_limit_w;
    assign poll_limit_w = word_at(rec_q, IDX_W'(4));

    regseq_timer #(.CNT_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_DECODE),
        .tick    (us_tick),
        .limit   (TMO_W'(poll_limit_w)),
        .expired (tmr_expired)
    );

    // ------------------------------------------------------------------
    // element field selection
    // ------------------------------------------------------------------
    logic [IDX_W-1:0]  addr_k, mask_k, val_k;
    logic [WORD_W-1:0] cur_addr, cur_mask, cur_val;
    logic [WORD_W-1:0] first_chain_mask;
    logic [WORD_W-1:0] poll_mask, poll_expect;
    logic              poll_match;

    always_comb begin
        if (op_q == OP_MERGE) begin
            addr_k = idx_q + idx_q + idx_q + IDX_W'(1);
            mask_k = idx_q + idx_q + idx_q + IDX_W'(2);
            val_k  = idx_q + idx_q + idx_q + IDX_W'(3);
        end else begin
            addr_k = IDX_W'(1);
            mask_k = idx_q + idx_q + IDX_W'(2);
            val_k  = idx_q + idx_q + IDX_W'(3);
        end
    end

    assign cur_addr         = word_at(rec_q, addr_k);
    assign cur_mask         = word_at(rec_q, mask_k);
    assign cur_val          = word_at(rec_q, val_k);
    assign first_chain_mask = word_at(rec_q, IDX_W'(2));
    assign poll_mask        = word_at(rec_q, IDX_W'(2));
    assign poll_expect      = word_at(rec_q, IDX_W'(3));
    assign poll_match       = ((rd_data & poll_mask) == poll_expect);

    // ------------------------------------------------------------------
    // next state
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (!dec_legal) begin
                    state_d = ST_FINISH;
                end else begin
                    unique case (dec_op)
                        OP_NULL:  state_d = ST_FINISH;
                        OP_MERGE: state_d = ST_RMW_NEXT;
                        OP_CHAIN: begin
                            if (dec_count == '0)
                                state_d = ST_FINISH;
                            else if (first_chain_mask == FULL_MASK)
                                state_d = ST_APPLY;
                            else
                                state_d = ST_READ;
                        end
                        OP_REPT:  state_d = ST_BURST_NEXT;
                        OP_POLL:  state_d = ST_POLL;
                        default:  state_d = ST_FINISH;
                    endcase
                end
            end
            ST_RMW_NEXT: begin
                if (idx_q == count_q)
                    state_d = ST_FINISH;
                else if (cur_mask == FULL_MASK)
                    state_d = ST_APPLY;
                else
                    state_d = ST_READ;
            end
            ST_BURST_NEXT: begin
                state_d = (idx_q == count_q) ? ST_FINISH : ST_WRITE;
            end
            ST_READ: begin
                if (rd_ack) state_d = ST_APPLY;
            end
            ST_APPLY: begin
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    unique case (op_q)
                        OP_MERGE: state_d = ST_RMW_NEXT;
                        OP_CHAIN: state_d = (idx_q + IDX_W'(1) == count_q)
                                            ? ST_FINISH : ST_APPLY;
                        OP_REPT:  state_d = ST_BURST_NEXT;
                        default:  state_d = ST_FINISH;
                    endcase
                end
            end
            ST_POLL: begin
                if (rd_ack && (poll_match || tmr_expired)) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ------------------------------------------------------------------
    // datapath registers
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q   <= '0;
            op_q    <= OP_NULL;
            count_q <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
            err_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        rec_q <= cmd_record;
                        idx_q <= '0;
                        err_q <= 1'b0;
                        tmo_q <= 1'b0;
                    end
                end
                ST_DECODE: begin
                    op_q    <= dec_op;
                    count_q <= dec_count;
                    if (!dec_legal) err_q <= 1'b1;
                end
                ST_READ: begin
                    if (rd_ack) acc_q <= rd_data;
                end
                ST_APPLY: begin
                    acc_q <= mask_merge(acc_q, cur_mask, cur_val);
                end
                ST_WRITE: begin
                    if (wr_ack) idx_q <= idx_q + IDX_W'(1);
                end
                ST_BURST_NEXT: begin
                    if (idx_q != count_q)
                        acc_q <= word_at(rec_q, idx_q + IDX_W'(2));
                end
                ST_POLL: begin
                    if (rd_ack && !poll_match && tmr_expired) tmo_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ------------------------------------------------------------------
    // outputs
    // ------------------------------------------------------------------
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        rd_req    = (state_q == ST_READ) || (state_q == ST_POLL);
        rd_addr   = (state_q == ST_POLL) ? word_at(rec_q, IDX_W'(1)) : cur_addr;
        wr_req    = (state_q == ST_WRITE);
        wr_addr   = cur_addr;
        wr_data   = acc_q;
        done      = (state_q == ST_FINISH);
        err       = err_q;
        timeout   = tmo_q;
    end

endmodule

// File: rtl/regseq_checks.sv
module regseq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        rd_req,
    input logic [31:0] rd_addr,
    input logic        rd_ack,
    input logic        wr_req,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_ack,
    input logic        done,
    input logic        err,
    input logic        timeout
);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!rd_req && !wr_req));

    assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!rd_req && !wr_req));

    assert_timeout_not_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !err);

    assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_wr_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

endmodule

bind regseq_engine regseq_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .done      (done),
    .err       (err),
    .timeout   (timeout)
);

// File: tb/regseq_engine_test.sv
module regseq_engine_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [511:0] cmd_record = '0;
    logic         us_tick = 1'b0;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_ack = 1'b0;
    logic [31:0]  rd_data = '0;
    logic         wr_req;
    logic [31:0]  wr_addr;
    logic [31:0]  wr_data;
    logic         wr_ack = 1'b0;
    logic         done, err, timeout;

    always #2.5 clk = ~clk;

    regseq_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_record(cmd_record), .us_tick(us_tick),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .done(done), .err(err), .timeout(timeout)
    );

    int vectors = 0;
    int fails   = 0;

    // register model and transaction log
    localparam logic [31:0] POLL_ADDR = 32'h0000_0100;
    logic [31:0] mem [32];
    logic [31:0] poll_cnt = '0;
    int          lg_n = 0;
    logic        lg_wr   [64];
    logic [31:0] lg_addr [64];
    logic [31:0] lg_data [64];

    logic got_err, got_tmo;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // bus slave: one-cycle acknowledge after each request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (rd_addr == POLL_ADDR) begin
                    rd_data  = poll_cnt;
                    poll_cnt = poll_cnt + 1;
                end else begin
                    rd_data = mem[rd_addr[6:2]];
                end
                if (lg_n < 64) begin
                    lg_wr[lg_n] = 1'b0; lg_addr[lg_n] = rd_addr; lg_data[lg_n] = rd_data;
                end
                lg_n++;
                rd_ack = 1'b1;
            end
            if (wr_ack) begin
                wr_ack = 1'b0;
            end else if (wr_req) begin
                mem[wr_addr[6:2]] = wr_data;
                if (lg_n < 64) begin
                    lg_wr[lg_n] = 1'b1; lg_addr[lg_n] = wr_addr; lg_data[lg_n] = wr_data;
                end
                lg_n++;
                wr_ack = 1'b1;
            end
        end
    end

    // microsecond tick every fourth cycle
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 us_tick = 1'b1;
            @(posedge clk);
            #1 us_tick = 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    function automatic logic [31:0] hdr(input logic [7:0] t, input logic [5:0] n);
        return {2'b00, n, 16'h0000, t};
    endfunction

    task automatic run_cmd(input logic [511:0] rec);
        lg_n = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_record = rec;
        cmd_valid  = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        got_err = err;
        got_tmo = timeout;
        @(negedge clk);
        chk("R11", "done width", {31'b0, done}, 32'd0);
    endtask

    task automatic chk_op(input string req, input int i, input logic w,
                          input logic [31:0] a, input logic [31:0] d);
        chk(req, $sformatf("op%0d kind", i), {31'b0, lg_wr[i]}, {31'b0, w});
        chk(req, $sformatf("op%0d addr", i), lg_addr[i], a);
        chk(req, $sformatf("op%0d data", i), lg_data[i], d);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "cmd_ready", {31'b0, cmd_ready}, 32'd1);
        chk("R1", "rd_req",    {31'b0, rd_req},    32'd0);
        chk("R1", "wr_req",    {31'b0, wr_req},    32'd0);
        chk("R1", "done/err/timeout", {29'b0, done, err, timeout}, 32'd0);
    endtask

    task automatic t_null;
        logic [511:0] r = '0;
        r[31:0] = hdr(8'd0, 6'd0);
        run_cmd(r);
        chk("R2", "null traffic", lg_n, 0);
        chk("R2", "null err", {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_merge_mixed;
        logic [511:0] r = '0;
        mem[1] = 32'hAABB_CCDD;
        r[31:0]    = hdr(8'd1, 6'd24);
        r[63:32]   = 32'h04; r[95:64]  = 32'h0000_FF00; r[127:96]  = 32'h0000_1200;
        r[159:128] = 32'h08; r[191:160] = 32'hFFFF_FFFF; r[223:192] = 32'hCAFE_F00D;
        run_cmd(r);
        chk("R3", "op count", lg_n, 3);
        chk_op("R3", 0, 1'b0, 32'h04, 32'hAABB_CCDD);
        chk_op("R3", 1, 1'b1, 32'h04, 32'hAABB_12DD);
        chk_op("R4", 2, 1'b1, 32'h08, 32'hCAFE_F00D);
        chk("R3", "err", {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_merge_full;
        logic [511:0] r = '0;
        r[31:0] = hdr(8'd1, 6'd60);
        for (int i = 0; i < 5; i++) begin
            r[32*(1+3*i) +: 32] = 32'h10 + 4*i;
            r[32*(2+3*i) +: 32] = 32'hFFFF_FFFF;
            r[32*(3+3*i) +: 32] = 32'h5000 + i;
        end
        run_cmd(r);
        chk("R4", "op count", lg_n, 5);
        for (int i = 0; i < 5; i++)
            chk_op("R4", i, 1'b1, 32'h10 + 4*i, 32'h5000 + i);
    endtask

    task automatic t_chain_read;
        logic [511:0] r = '0;
        mem[3] = 32'h1234_5678;
        r[31:0]    = hdr(8'd2, 6'd28);
        r[63:32]   = 32'h0C;
        r[95:64]   = 32'h0000_00FF; r[127:96]  = 32'h0000_00AA;
        r[159:128] = 32'hFF00_0000; r[191:160] = 32'h5500_0000;
        r[223:192] = 32'h0000_FF00; r[255:224] = 32'h0000_0100;
        run_cmd(r);
        chk("R5", "op count", lg_n, 4);
        chk_op("R5", 0, 1'b0, 32'h0C, 32'h1234_5678);
        chk_op("R5", 1, 1'b1, 32'h0C, 32'h1234_56AA);
        chk_op("R5", 2, 1'b1, 32'h0C, 32'h5534_56AA);
        chk_op("R5", 3, 1'b1, 32'h0C, 32'h5534_01AA);
    endtask

    task automatic t_chain_noread;
        logic [511:0] r = '0;
        r[31:0]    = hdr(8'd2, 6'd20);
        r[63:32]   = 32'h14;
        r[95:64]   = 32'hFFFF_FFFF; r[127:96]  = 32'h0F0F_0F0F;
        r[159:128] = 32'hF000_0000; r[191:160] = 32'h3000_0000;
        run_cmd(r);
        chk("R6", "op count", lg_n, 2);
        chk_op("R6", 0, 1'b1, 32'h14, 32'h0F0F_0F0F);
        chk_op("R6", 1, 1'b1, 32'h14, 32'h3F0F_0F0F);
    endtask

    task automatic t_burst;
        logic [511:0] r = '0;
        r[31:0]  = hdr(8'd3, 6'd60);
        r[63:32] = 32'h18;
        for (int i = 0; i < 14; i++) r[32*(2+i) +: 32] = 32'h100 + i;
        run_cmd(r);
        chk("R7", "op count", lg_n, 14);
        for (int i = 0; i < 14; i++)
            chk_op("R7", i, 1'b1, 32'h18, 32'h100 + i);
    endtask

    function automatic logic [511:0] poll_rec(input logic [31:0] m, input logic [31:0] e,
                                              input logic [31:0] lim);
        logic [511:0] r = '0;
        r[31:0]    = hdr(8'd4, 6'd16);
        r[63:32]   = POLL_ADDR;
        r[95:64]   = m;
        r[127:96]  = e;
        r[159:128] = lim;
        return r;
    endfunction

    task automatic t_poll_match;
        poll_cnt = 0;
        run_cmd(poll_rec(32'hFF, 32'h3, 32'd1000));
        chk("R8", "read count", lg_n, 4);
        chk("R8", "last read", lg_data[3], 32'h3);
        chk("R8", "timeout", {31'b0, got_tmo}, 32'd0);
    endtask

    task automatic t_poll_expire;
        poll_cnt = 0;
        run_cmd(poll_rec(32'hFF, 32'h1FF, 32'd3));
        chk("R9", "timeout", {31'b0, got_tmo}, 32'd1);
        chk("R9", "err", {31'b0, got_err}, 32'd0);
        chk("R9", "several reads", {31'b0, (lg_n >= 2)}, 32'd1);
        chk("R9", "read addr", lg_addr[0], POLL_ADDR);
        poll_cnt = 0;
        run_cmd(poll_rec(32'hFF, 32'h1FF, 32'd0));
        chk("R9", "zero-limit reads", lg_n, 1);
        chk("R9", "zero-limit timeout", {31'b0, got_tmo}, 32'd1);
    endtask

    task automatic t_reject(input logic [7:0] t, input logic [5:0] n);
        logic [511:0] r = '0;
        r[31:0]  = hdr(t, n);
        r[63:32] = 32'h04;
        r[95:64] = 32'h0000_00FF;
        run_cmd(r);
        chk("R10", $sformatf("err t%0d n%0d", t, n), {31'b0, got_err}, 32'd1);
        chk("R10", $sformatf("traffic t%0d n%0d", t, n), lg_n, 0);
    endtask

    task automatic t_empty;
        logic [511:0] r = '0;
        r[31:0] = hdr(8'd1, 6'd0);
        run_cmd(r);
        chk("R12", "merge empty traffic", lg_n, 0);
        chk("R12", "merge empty err", {31'b0, got_err}, 32'd0);
        r[31:0] = hdr(8'd2, 6'd4);
        run_cmd(r);
        chk("R12", "chain empty traffic", lg_n, 0);
        r[31:0] = hdr(8'd3, 6'd4);
        run_cmd(r);
        chk("R12", "repeat empty traffic", lg_n, 0);
        chk("R12", "repeat empty err", {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_busy_ignore;
        logic [511:0] r = '0;
        logic [511:0] other = '0;
        r[31:0]  = hdr(8'd3, 6'd12);
        r[63:32] = 32'h1C;
        r[95:64] = 32'hA1; r[127:96] = 32'hA2;
        other[31:0]  = hdr(8'd3, 6'd8);
        other[63:32] = 32'h20;
        other[95:64] = 32'hEE;
        lg_n = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_record = r;
        cmd_valid  = 1'b1;
        @(posedge clk);
        #1 cmd_record = other;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11", "ready while busy", {31'b0, cmd_ready}, 32'd0);
        end
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R11", "ops with ignored offer", lg_n, 2);
        chk_op("R11", 1, 1'b1, 32'h1C, 32'hA2);
        chk("R11", "idle again", {31'b0, cmd_ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        t_reset;
        #1 rst_n = 1'b1;
        t_null;
        t_merge_mixed;
        t_merge_full;
        t_chain_read;
        t_chain_noread;
        t_burst;
        t_poll_match;
        t_poll_expire;
        t_reject(8'd9, 6'd0);
        t_reject(8'd1, 6'd13);
        t_reject(8'd2, 6'd8);
        t_reject(8'd2, 6'd0);
        t_reject(8'd3, 6'd62);
        t_reject(8'd4, 6'd12);
        t_empty;
        t_busy_ignore;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule